// File: doc/BRIEF.md
# Calibrated Power and RMS Computation Engine

This block sits behind two decimated sample streams, one for line voltage and one for line current. Each incoming sample pair first has a per-channel DC offset added and then a per-channel gain applied. The calibrated values are shown on instantaneous output registers. The engine then accumulates the squared voltage, the squared current and the voltage-current product over a block of samples whose length is programmable.

When a block ends, the accumulated sums are snapshotted and the accumulators restart at once, so no sample is lost. A post-processing pipeline divides the three sums by the block length and takes integer square roots of the two mean squares. It then latches RMS voltage, RMS current, active (average) power and apparent power together in a single cycle and raises a ready flag. The flag stays high until the host acknowledges it. A run input gates the whole block: while it is low, samples are ignored and the partial block is discarded.

Top module: `pe_power_engine`

## Requirements
- R1: One cycle after a clock edge that sees `smp_vld` high while `run` is high, `v_inst` holds floor((v_smp + v_off) * v_gain / 2^14), and `i_inst` likewise from the current channel inputs. Gains are unsigned with 14 fraction bits, so 16384 means unity. The instantaneous outputs change at no other time.
- R2: A calibrated value above 8388607 is clamped to 8388607, and one below -8388608 is clamped to -8388608. The offset sum itself never wraps.
- R3: At the end of a block of N samples, `v_rms` becomes floor(sqrt(floor(sum of v_cal^2 / N))).
- R4: `i_rms` is formed in the same way from the calibrated current samples of the same block.
- R5: `p_act` is the sum of v_cal*i_cal over the block, divided by N and truncated toward zero (signed). `s_app` is `v_rms * i_rms` from the same update.
- R6: All four results change together, only in the cycle in which `rdy` is set. `rdy` stays high until `ack` is asserted, and `ack` clears it on the next edge.
- R7: A new `cyc_len` value written in the middle of a block does not shorten or lengthen that block. It sets the length of the following block.
- R8: While `run` is low, samples are ignored: the instantaneous outputs hold and no block completes. On `run` going high, a fresh block starts from zero samples.
- R9: A `cyc_len` of 0 is treated as a block length of 1.
- R10: After reset, every result and instantaneous output reads 0 and `rdy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run | input | 1 | High to accumulate; low discards the current block |
| smp_vld | input | 1 | One-cycle strobe, sample pair present |
| v_smp | input | 24 | Signed voltage sample |
| i_smp | input | 24 | Signed current sample |
| cyc_len | input | 24 | Samples per computation block (0 acts as 1) |
| v_off | input | 24 | Signed voltage offset, added first |
| i_off | input | 24 | Signed current offset, added first |
| v_gain | input | 16 | Unsigned voltage gain, 14 fraction bits |
| i_gain | input | 16 | Unsigned current gain, 14 fraction bits |
| ack | input | 1 | Clears the ready flag |
| v_inst | output | 24 | Calibrated instantaneous voltage |
| i_inst | output | 24 | Calibrated instantaneous current |
| v_rms | output | 24 | RMS voltage of the last block |
| i_rms | output | 24 | RMS current of the last block |
| p_act | output | 48 | Signed active power of the last block |
| s_app | output | 48 | Apparent power of the last block |
| rdy | output | 1 | Set when results update, held until ack |

## Verification
The assertions assume that a block never ends while the divide and square-root pipeline is still busy with the previous block. In other words, the block length times the spacing of valid strobes must exceed the pipeline latency, which is about one hundred cycles. The bench spaces its samples 120 cycles apart, so even single-sample blocks meet this assumption. The assertions also assume that `ack` is never raised in the same cycle as an update. The bench raises `ack` only after `rdy` is already high or before a new block begins.

// File: rtl/pe_power_engine_pkg.sv
package pe_power_engine_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_DIV, ST_SQRT} eng_st_e;
endpackage

// File: rtl/pe_calib.sv
// Offset-then-gain correction of one channel, floored and clamped.
module pe_calib #(
  parameter int SW = 24,
  parameter int GW = 16,
  parameter int GF = 14
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 en,
  input  logic signed [SW-1:0] x,
  input  logic signed [SW-1:0] off,
  input  logic        [GW-1:0] gain,
  output logic signed [SW-1:0] y
);
  localparam int PW = SW + GW + 2;
  localparam logic signed [PW-1:0] MAXV = $signed({{(GW+3){1'b0}}, {(SW-1){1'b1}}});
  localparam logic signed [PW-1:0] MINV = $signed({{(GW+3){1'b1}}, {(SW-1){1'b0}}});

  logic signed [SW:0]   corr;
  logic signed [PW-1:0] prod;
  logic signed [PW-1:0] shd;

  assign corr = x + off;
  assign prod = corr * $signed({1'b0, gain});
  assign shd  = prod >>> GF;

  always_ff @(posedge clk) begin
    if (rst) begin
      y <= '0;
    end else if (en) begin
      if (shd > MAXV)      y <= MAXV[SW-1:0];
      else if (shd < MINV) y <= MINV[SW-1:0];
      else                 y <= shd[SW-1:0];
    end
  end
endmodule

// File: rtl/pe_udiv.sv
// Bit-serial restoring divider, one quotient bit per cycle.
module pe_udiv #(
  parameter int NW = 72,
  parameter int DW = 24,
  parameter int QW = 48
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [NW-1:0] num,
  input  logic [DW-1:0] den,
  output logic          done,
  output logic [QW-1:0] quo
);
  localparam int KW = $clog2(NW + 1);

  logic [NW-1:0] q;
  logic [DW-1:0] r;
  logic [DW-1:0] d;
  logic [KW-1:0] k;
  logic          act;
  logic [DW:0]   trial;
  logic [DW:0]   diff;
  logic          ge;

  assign trial = {r, q[NW-1]};
  assign ge    = trial >= {1'b0, d};
  assign diff  = trial - {1'b0, d};
  assign quo   = q[QW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0; r <= '0; d <= '0; k <= '0; act <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        q <= num; r <= '0; d <= den; k <= KW'(NW); act <= 1'b1;
      end else if (act) begin
        q <= {q[NW-2:0], ge};
        r <= ge ? diff[DW-1:0] : trial[DW-1:0];
        k <= k - 1'b1;
        if (k == KW'(1)) begin
          act  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pe_isqrt.sv
// Digit-by-digit integer square root, one root bit per cycle.
module pe_isqrt #(
  parameter int RW = 24
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [2*RW-1:0] rad,
  output logic            done,
  output logic [RW-1:0]   root
);
  localparam int KW = $clog2(RW + 1);

  logic [2*RW-1:0] a;
  logic [RW:0]     r;
  logic [KW-1:0]   k;
  logic            act;
  logic [RW+2:0]   trial;
  logic [RW+2:0]   tst;
  logic [RW+2:0]   diff;
  logic            ge;

  assign trial = {r, a[2*RW-1:2*RW-2]};
  assign tst   = {1'b0, root, 2'b01};
  assign ge    = trial >= tst;
  assign diff  = trial - tst;

  always_ff @(posedge clk) begin
    if (rst) begin
      a <= '0; r <= '0; root <= '0; k <= '0; act <= 1'b0; done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        a <= rad; r <= '0; root <= '0; k <= KW'(RW); act <= 1'b1;
      end else if (act) begin
        a    <= {a[2*RW-3:0], 2'b00};
        r    <= ge ? diff[RW:0] : trial[RW:0];
        root <= {root[RW-2:0], ge};
        k    <= k - 1'b1;
        if (k == KW'(1)) begin
          act  <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pe_power_engine.sv
module pe_power_engine #(
  parameter int SW = 24,
  parameter int GW = 16,
  parameter int GF = 14,
  parameter int CW = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   run,
  input  logic                   smp_vld,
  input  logic signed [SW-1:0]   v_smp,
  input  logic signed [SW-1:0]   i_smp,
  input  logic        [CW-1:0]   cyc_len,
  input  logic signed [SW-1:0]   v_off,
  input  logic signed [SW-1:0]   i_off,
  input  logic        [GW-1:0]   v_gain,
  input  logic        [GW-1:0]   i_gain,
  input  logic                   ack,
  output logic signed [SW-1:0]   v_inst,
  output logic signed [SW-1:0]   i_inst,
  output logic        [SW-1:0]   v_rms,
  output logic        [SW-1:0]   i_rms,
  output logic signed [2*SW-1:0] p_act,
  output logic        [2*SW-1:0] s_app,
  output logic                   rdy
);
  import pe_power_engine_pkg::*;

  localparam int AW  = 2 * SW + CW;
  localparam int PQW = 2 * SW;

  // calibration, one instance per channel
  logic signed [SW-1:0] ch_x   [2];
  logic signed [SW-1:0] ch_off [2];
  logic        [GW-1:0] ch_g   [2];
  logic signed [SW-1:0] ch_cal [2];
  logic                 cal_en;

  assign ch_x[0] = v_smp;  assign ch_off[0] = v_off;  assign ch_g[0] = v_gain;
  assign ch_x[1] = i_smp;  assign ch_off[1] = i_off;  assign ch_g[1] = i_gain;
  assign cal_en  = smp_vld && run;

  for (genvar c = 0; c < 2; c++) begin : g_ch
    pe_calib #(.SW(SW), .GW(GW), .GF(GF)) u_cal (
      .clk(clk), .rst(rst), .en(cal_en),
      .x(ch_x[c]), .off(ch_off[c]), .gain(ch_g[c]), .y(ch_cal[c]));
  end

  assign v_inst = ch_cal[0];
  assign i_inst = ch_cal[1];

  logic cal_vld;
  always_ff @(posedge clk) cal_vld <= !rst && cal_en;

  // block accumulation
  logic signed [2*SW-1:0] sq_v, sq_i, pp;
  logic        [AW-1:0]   acc_v, acc_i, snap_v, snap_i;
  logic signed [AW-1:0]   acc_p, snap_p;
  logic        [CW-1:0]   cnt, n_cur, n_snap, n_eff;
  logic                   start;
  logic                   last;

  assign sq_v  = ch_cal[0] * ch_cal[0];
  assign sq_i  = ch_cal[1] * ch_cal[1];
  assign pp    = ch_cal[0] * ch_cal[1];
  assign n_eff = (cyc_len == '0) ? CW'(1) : cyc_len;
  assign last  = (cnt == n_cur - CW'(1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      acc_v <= '0; acc_i <= '0; acc_p <= '0; cnt <= '0;
      n_cur <= n_eff; start <= 1'b0;
      if (rst) begin
        snap_v <= '0; snap_i <= '0; snap_p <= '0; n_snap <= CW'(1);
      end
    end else begin
      start <= 1'b0;
      if (cal_vld) begin
        if (last) begin
          snap_v <= acc_v + {{CW{1'b0}}, sq_v};
          snap_i <= acc_i + {{CW{1'b0}}, sq_i};
          snap_p <= acc_p + {{CW{pp[2*SW-1]}}, pp};
          n_snap <= n_cur;
          n_cur  <= n_eff;
          acc_v  <= '0; acc_i <= '0; acc_p <= '0; cnt <= '0;
          start  <= 1'b1;
        end else begin
          acc_v <= acc_v + {{CW{1'b0}}, sq_v};
          acc_i <= acc_i + {{CW{1'b0}}, sq_i};
          acc_p <= acc_p + {{CW{pp[2*SW-1]}}, pp};
          cnt   <= cnt + CW'(1);
        end
      end
    end
  end

  // post-processing: three dividers, then two square roots
  logic          p_neg;
  logic [AW-1:0] div_num [3];
  logic [PQW-1:0] div_q  [3];
  logic [2:0]    div_done;
  logic [1:0]    sq_done;
  logic [SW-1:0] sq_root [2];
  logic          sq_start;
  logic          fin;
  eng_st_e       state;

  assign p_neg      = snap_p[AW-1];
  assign div_num[0] = snap_v;
  assign div_num[1] = snap_i;
  assign div_num[2] = p_neg ? (~snap_p + AW'(1)) : snap_p;

  for (genvar g = 0; g < 3; g++) begin : g_div
    pe_udiv #(.NW(AW), .DW(CW), .QW(PQW)) u_div (
      .clk(clk), .rst(rst), .start(start), .num(div_num[g]), .den(n_snap),
      .done(div_done[g]), .quo(div_q[g]));
  end

  assign sq_start = (state == ST_DIV) && (&div_done);

  for (genvar g = 0; g < 2; g++) begin : g_sqrt
    pe_isqrt #(.RW(SW)) u_sqrt (
      .clk(clk), .rst(rst), .start(sq_start), .rad(div_q[g]),
      .done(sq_done[g]), .root(sq_root[g]));
  end

  assign fin = (state == ST_SQRT) && (&sq_done);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      v_rms <= '0; i_rms <= '0; p_act <= '0; s_app <= '0; rdy <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) state <= ST_DIV;
        ST_DIV:  if (sq_start) state <= ST_SQRT;
        default: if (fin) state <= ST_IDLE;
      endcase
      if (fin) begin
        v_rms <= sq_root[0];
        i_rms <= sq_root[1];
        s_app <= sq_root[0] * sq_root[1];
        p_act <= p_neg ? (PQW'(0) - div_q[2]) : div_q[2];
        rdy   <= 1'b1;
      end else if (ack) begin
        rdy <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/pe_power_engine_chk.sv
module pe_power_engine_chk #(
  parameter int SW = 24
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   run,
  input logic                   smp_vld,
  input logic                   ack,
  input logic                   rdy,
  input logic                   fin,
  input logic                   start,
  input logic                   busy,
  input logic signed [SW-1:0]   v_inst,
  input logic signed [SW-1:0]   i_inst,
  input logic        [SW-1:0]   v_rms,
  input logic        [SW-1:0]   i_rms,
  input logic signed [2*SW-1:0] p_act,
  input logic        [2*SW-1:0] s_app,
  input logic        [2*SW-1:0] mean_v,
  input logic        [SW-1:0]   root_v
);
  // R3: input assumption, a block never ends while the pipeline is busy
  p_block_spacing_r3: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);

  // R3: the root unit yields the floor of the square root of the divider's mean
  p_root_floor_r3: assert property (@(posedge clk) disable iff (rst)
    fin |-> ((64'(root_v) * 64'(root_v) <= 64'(mean_v)) &&
             ((64'(root_v) + 64'd1) * (64'(root_v) + 64'd1) > 64'(mean_v))));

  // R1: instantaneous outputs move only after a valid strobe
  p_inst_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !smp_vld |=> ($stable(v_inst) && $stable(i_inst)));

  // R8: a strobe while run is low leaves the instantaneous outputs alone
  p_run_gate_r8: assert property (@(posedge clk) disable iff (rst)
    !run |=> ($stable(v_inst) && $stable(i_inst)));

  // R6: results only change on an update
  p_res_stable_r6: assert property (@(posedge clk) disable iff (rst)
    !fin |=> ($stable(v_rms) && $stable(i_rms) && $stable(p_act) && $stable(s_app)));

  // R6: flag behaviour
  p_rdy_set_r6: assert property (@(posedge clk) disable iff (rst)
    fin |=> rdy);
  p_rdy_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (rdy && !ack) |=> rdy);
  p_ack_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (ack && !fin) |=> !rdy);
endmodule

bind pe_power_engine pe_power_engine_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst(rst), .run(run), .smp_vld(smp_vld), .ack(ack), .rdy(rdy),
  .fin(fin), .start(start), .busy(state != pe_power_engine_pkg::ST_IDLE),
  .v_inst(v_inst), .i_inst(i_inst), .v_rms(v_rms), .i_rms(i_rms),
  .p_act(p_act), .s_app(s_app), .mean_v(div_q[0]), .root_v(sq_root[0]));

// File: tb/pe_power_engine_test.sv
module pe_power_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 120;
  localparam longint UNITY = 16384;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic run = 1'b0;
  logic smp_vld = 1'b0;
  logic signed [23:0] v_smp = '0, i_smp = '0, v_off = '0, i_off = '0;
  logic [23:0] cyc_len = 24'd4;
  logic [15:0] v_gain = 16'd16384, i_gain = 16'd16384;
  logic ack = 1'b0;
  logic signed [23:0] v_inst, i_inst;
  logic [23:0] v_rms, i_rms;
  logic signed [47:0] p_act;
  logic [47:0] s_app;
  logic rdy;

  int n_chk = 0;
  int n_fail = 0;
  longint mv, mi, mp;

  always #(CLK_PERIOD/2) clk = ~clk;

  pe_power_engine uut (
    .clk(clk), .rst(rst), .run(run), .smp_vld(smp_vld), .v_smp(v_smp), .i_smp(i_smp),
    .cyc_len(cyc_len), .v_off(v_off), .i_off(i_off), .v_gain(v_gain), .i_gain(i_gain),
    .ack(ack), .v_inst(v_inst), .i_inst(i_inst), .v_rms(v_rms), .i_rms(i_rms),
    .p_act(p_act), .s_app(s_app), .rdy(rdy));

  function automatic longint calm(longint x, longint off, longint g);
    longint t = ((x + off) * g) >>> 14;
    if (t > 8388607) t = 8388607;
    if (t < -8388608) t = -8388608;
    return t;
  endfunction

  function automatic longint isqrt(longint m);
    longint r = 0;
    for (int b = 23; b >= 0; b--) begin
      longint t = r | (longint'(1) << b);
      if (t * t <= m) r = t;
    end
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(input longint x, input longint y, input bit add);
    @(negedge clk);
    v_smp = x[23:0]; i_smp = y[23:0]; smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
    if (add) begin
      longint cv = calm(x, longint'(v_off), longint'(v_gain));
      longint ci = calm(y, longint'(i_off), longint'(i_gain));
      mv += cv * cv; mi += ci * ci; mp += cv * ci;
    end
  endtask

  task automatic gap();
    repeat (GAP) @(negedge clk);
  endtask

  task automatic restart(input int len);
    @(negedge clk);
    run = 1'b0; cyc_len = len[23:0]; ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
    @(negedge clk);
    run = 1'b1;
    mv = 0; mi = 0; mp = 0;
  endtask

  task automatic wait_rdy(input string tag);
    for (int k = 0; k < 600 && !rdy; k++) @(negedge clk);
    chk(rdy == 1'b1, tag, longint'(rdy), 1);
  endtask

  task automatic check_res(input longint n, input string tag);
    longint vr = isqrt(mv / n);
    longint ir = isqrt(mi / n);
    longint pa = mp / n;
    chk(longint'(v_rms) == vr, {tag, " R3 v_rms"}, longint'(v_rms), vr);
    chk(longint'(i_rms) == ir, {tag, " R4 i_rms"}, longint'(i_rms), ir);
    chk(longint'(p_act) == pa, {tag, " R5 p_act"}, longint'(p_act), pa);
    chk(longint'(s_app) == vr * ir, {tag, " R5 s_app"}, longint'(s_app), vr * ir);
  endtask

  task automatic t_reset();
    chk(v_inst == 0 && i_inst == 0, "R10 inst after reset", longint'(v_inst), 0);
    chk(v_rms == 0 && i_rms == 0, "R10 rms after reset", longint'(v_rms), 0);
    chk(p_act == 0 && s_app == 0, "R10 power after reset", longint'(p_act), 0);
    chk(rdy == 1'b0, "R10 rdy after reset", longint'(rdy), 0);
  endtask

  task automatic t_calib();
    restart(1000);
    v_off = -24'sd200; v_gain = 16'd24576; i_off = 24'sd100; i_gain = 16'd8192;
    send(1000, -5000, 1'b0);
    chk(longint'(v_inst) == 1200, "R1 offset+gain v", longint'(v_inst), 1200);
    chk(longint'(i_inst) == -2450, "R1 offset+gain i", longint'(i_inst), -2450);
    i_off = '0;
    send(7, -3, 1'b0);
    chk(longint'(i_inst) == calm(-3, 0, 8192), "R1 floor of negative", longint'(i_inst), -2);
    v_off = '0; v_gain = 16'd32768; i_gain = 16'd32768;
    send(8000000, -8000000, 1'b0);
    chk(longint'(v_inst) == 8388607, "R2 clamp high", longint'(v_inst), 8388607);
    chk(longint'(i_inst) == -8388608, "R2 clamp low", longint'(i_inst), -8388608);
    v_off = 24'sd8388607; v_gain = 16'd16384;
    send(8388607, 0, 1'b0);
    chk(longint'(v_inst) == 8388607, "R2 offset sum clamp", longint'(v_inst), 8388607);
    v_off = '0; i_gain = 16'd16384;
  endtask

  task automatic t_block_a();
    restart(4);
    send(1000, 500, 1'b1); gap();
    send(-2000, 600, 1'b1); gap();
    send(3000, -700, 1'b1); gap();
    send(-4000, 800, 1'b1);
    wait_rdy("R6 ready after block A");
    check_res(4, "block A");
  endtask

  task automatic t_hold();
    longint keep = longint'(v_rms);
    send(5555, 6666, 1'b0); gap();
    send(-5555, 6666, 1'b0); gap();
    chk(rdy == 1'b1, "R6 rdy held without ack", longint'(rdy), 1);
    chk(longint'(v_rms) == keep, "R6 result stable mid-block", longint'(v_rms), keep);
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    chk(rdy == 1'b0, "R6 ack clears rdy", longint'(rdy), 0);
  endtask

  task automatic t_block_b();
    restart(3);
    send(8000000, -8000000, 1'b1); gap();
    send(-7000000, 7000000, 1'b1); gap();
    send(6000000, -5000000, 1'b1);
    wait_rdy("R6 ready after block B");
    check_res(3, "block B full-scale negative power");
  endtask

  task automatic t_block_c();
    restart(5);
    v_off = 24'sd300; i_off = -24'sd250; v_gain = 16'd20000; i_gain = 16'd12000;
    send(123456, 65432, 1'b1); gap();
    send(-98765, -1111, 1'b1); gap();
    send(4000000, 2000, 1'b1); gap();
    send(-17, 999999, 1'b1); gap();
    send(777777, -333333, 1'b1);
    wait_rdy("R6 ready after block C");
    check_res(5, "block C calibrated");
    v_off = '0; i_off = '0; v_gain = 16'd16384; i_gain = 16'd16384;
  endtask

  task automatic t_len_change();
    restart(4);
    send(10000, 3000, 1'b1); gap();
    send(-20000, 4000, 1'b1); gap();
    cyc_len = 24'd2;
    gap();
    chk(rdy == 1'b0, "R7 block not cut short", longint'(rdy), 0);
    send(30000, -5000, 1'b1); gap();
    send(40000, 6000, 1'b1);
    wait_rdy("R7 ready after old length");
    check_res(4, "R7 old length kept");
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
    mv = 0; mi = 0; mp = 0;
    gap();
    send(-1500, -1500, 1'b1); gap();
    send(2500, 900, 1'b1);
    wait_rdy("R7 ready after new length");
    check_res(2, "R7 new length applied");
  endtask

  task automatic t_run_gate();
    longint keep;
    restart(3);
    send(900000, 900000, 1'b0); gap();
    send(800000, -800000, 1'b0); gap();
    run = 1'b0;
    keep = longint'(v_inst);
    send(12345, 54321, 1'b0);
    chk(longint'(v_inst) == keep, "R8 sample ignored while stopped", longint'(v_inst), keep);
    gap();
    chk(rdy == 1'b0, "R8 no block completes while stopped", longint'(rdy), 0);
    run = 1'b1;
    mv = 0; mi = 0; mp = 0;
    send(100, 200, 1'b1); gap();
    send(-300, 400, 1'b1); gap();
    send(500, -600, 1'b1);
    wait_rdy("R8 ready after restart");
    check_res(3, "R8 fresh block only");
  endtask

  task automatic t_zero_len();
    restart(0);
    send(-54321, 1234, 1'b1);
    wait_rdy("R9 ready after single sample");
    check_res(1, "R9 zero length acts as one");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R6 actual=timeout expected=completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_calib();
    t_block_a();
    t_hold();
    t_block_b();
    t_block_c();
    t_len_change();
    t_run_gate();
    t_zero_len();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule